// File: doc/BRIEF.md
# Latency-Insensitive Point-to-Point Message Link

This block carries fixed-width messages in one direction from a producer to a consumer. It is lossless and keeps messages in order. Both sides use a valid/ready handshake. A message moves on the producer side in any cycle where `in_valid` and `in_ready` are both high. It moves on the consumer side in any cycle where `out_valid` and `out_ready` are both high. The producer must hold `in_valid` low while `in_ready` is low. The consumer may apply back-pressure at any time by holding `out_ready` low. While it does so, the link keeps the offered message on `out_data` in the buffered variants.

A build parameter picks one of three storage structures, each with its own timing:
- **Single-slot variant:** one register with an empty/full state. It has one cycle of latency forward and one cycle backward.
- **Two-slot variant:** a small two-entry queue. Its output is multiplexed between the two registers. It sustains one message per cycle after a one-cycle fill.
- **Pass-through variant:** one register plus a combinational bypass. A message offered to an empty link reaches the consumer in the same cycle. `in_ready` follows `out_ready` without delay.

Each variant has at least one register per data bit and one register of control, so a held message is never dropped under back-pressure. A sticky flag records any write attempted while the link was not ready.

Top module: `chan_link`

## Requirements
- R1: Every message accepted on the producer side is delivered exactly once on the consumer side, in acceptance order, for every variant; no message is created that was not accepted.
- R2: Single-slot variant (KIND = 0): `in_ready` is high exactly when the slot is empty. A message accepted in cycle n is offered (`out_valid` high, `out_data` equal to it) from cycle n+1. After a read in cycle m, `in_ready` stays low in cycle m and rises in cycle m+1.
- R3: With a producer that writes whenever allowed and a consumer that always reads, starting empty, the number of deliveries in a 20-cycle window is 10 for KIND = 0, 19 for KIND = 1 and 20 for KIND = 2.
- R4: Two-slot variant (KIND = 1): it holds up to two messages. `in_ready` is high whenever fewer than two are held. A message accepted in cycle n is offered from cycle n+1, and the older held message is always offered first.
- R5: Pass-through variant (KIND = 2): when its register is empty, an accepted message appears on `out_data` with `out_valid` high in the same cycle. If it is read in that cycle, nothing is retained.
- R6: Pass-through variant: a stored message is offered ahead of any new bypass message. `in_ready` is low exactly when the register is full and `out_ready` is low. A write accepted while the full register is being read is stored and offered in the next cycle.
- R7: A write attempted while `in_ready` is low is ignored: it is never delivered, and it sets `proto_err` in the following cycle. `proto_err` then stays high until reset, and never rises without such a write.
- R8: For KIND = 0 and 1, while `out_valid` is high and `out_ready` is low, the next cycle still has `out_valid` high with `out_data` unchanged.
- R9: After reset, `out_valid` is low, `in_ready` is high and `proto_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Link can accept a message this cycle |
| in_data | input | W | Producer message |
| out_valid | output | 1 | A message is offered on `out_data` |
| out_ready | input | 1 | Consumer takes the offered message |
| out_data | output | W | Message offered to the consumer |
| proto_err | output | 1 | Sticky: a write was attempted while `in_ready` was low |

## Verification
The bench builds three copies side by side, one per KIND value (0, 1, 2), each with a 16-bit message width and its own random seed. This puts the different handshake timings next to each other: the single slot's alternating ready, the two-slot queue's full point and older-first ordering, and the pass-through's same-cycle bypass and its ready tied to the consumer. The narrow width keeps the message values readable in failure lines. Every width-dependent path is still exercised, because messages are random values across the full 16 bits.

// File: rtl/chan_link_pkg.sv
`timescale 1ns/1ps
package chan_link_pkg;
  // Storage structure selector for the link
  typedef enum logic [1:0] {
    LINK_SINGLE = 2'd0,
    LINK_DUAL   = 2'd1,
    LINK_WIRE   = 2'd2
  } link_kind_e;
endpackage

// File: rtl/chan_link_slot1.sv
`timescale 1ns/1ps
// One storage slot, empty/full, one cycle each way
module chan_link_slot1 #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic         s_ready,
  output logic         m_valid,
  output logic [W-1:0] m_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (wr) begin
      full_q <= 1'b1;
      data_q <= wr_data;
    end else if (full_q && rd_req) begin
      full_q <= 1'b0;
    end
  end

  assign s_ready = !full_q;
  assign m_valid = full_q;
  assign m_data  = data_q;
endmodule

// File: rtl/chan_link_slot2.sv
`timescale 1ns/1ps
// Two-entry queue, output muxed between the slots
module chan_link_slot2 #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic         s_ready,
  output logic         m_valid,
  output logic [W-1:0] m_data
);
  localparam int DEPTH = 2;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic          head_q;
  logic [CW-1:0] cnt_q;
  logic          tail;
  logic          pop;

  assign tail = head_q ^ cnt_q[0];
  assign pop  = rd_req && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (pop) head_q <= !head_q;
      cnt_q <= cnt_q + CW'(wr) - CW'(pop);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot_q[i] <= '0;
      else if (wr && (tail == 1'(i))) slot_q[i] <= wr_data;
    end
  end

  assign s_ready = (cnt_q != CW'(DEPTH));
  assign m_valid = (cnt_q != '0);
  assign m_data  = slot_q[head_q];
endmodule

// File: rtl/chan_link_bypass.sv
`timescale 1ns/1ps
// One slot with same-cycle bypass; stored message wins
module chan_link_bypass #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic         s_ready,
  output logic         m_valid,
  output logic [W-1:0] m_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (full_q) begin
      if (rd_req) full_q <= wr;
      if (wr) data_q <= wr_data;
    end else if (wr && !rd_req) begin
      full_q <= 1'b1;
      data_q <= wr_data;
    end
  end

  assign s_ready = !full_q || rd_req;
  assign m_valid = full_q || wr;
  assign m_data  = full_q ? data_q : wr_data;
endmodule

// File: rtl/chan_link_errflag.sv
`timescale 1ns/1ps
// Sticky record of writes offered while not ready
module chan_link_errflag (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_ready,
  output logic err
);
  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else if (in_valid && !in_ready) err <= 1'b1;
  end
endmodule

// File: rtl/chan_link.sv
`timescale 1ns/1ps
module chan_link
  import chan_link_pkg::*;
#(
  parameter int         W    = 33,
  parameter link_kind_e KIND = LINK_SINGLE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         proto_err
);
  logic accept;
  assign accept = in_valid && in_ready;

  if (KIND == LINK_DUAL) begin : g_dual
    chan_link_slot2 #(.W(W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr(accept), .wr_data(in_data),
      .rd_req(out_ready), .s_ready(in_ready), .m_valid(out_valid), .m_data(out_data)
    );
  end else if (KIND == LINK_WIRE) begin : g_wire
    chan_link_bypass #(.W(W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr(accept), .wr_data(in_data),
      .rd_req(out_ready), .s_ready(in_ready), .m_valid(out_valid), .m_data(out_data)
    );
  end else begin : g_single
    chan_link_slot1 #(.W(W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr(accept), .wr_data(in_data),
      .rd_req(out_ready), .s_ready(in_ready), .m_valid(out_valid), .m_data(out_data)
    );
  end

  chan_link_errflag u_err (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .err(proto_err)
  );
endmodule

// File: rtl/chan_link_chk.sv
`timescale 1ns/1ps
module chan_link_chk
  import chan_link_pkg::*;
#(
  parameter int         W    = 33,
  parameter link_kind_e KIND = LINK_SINGLE
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         proto_err
);
  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> proto_err);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  if (KIND == LINK_SINGLE) begin : g_single
    // R2
    single_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && !in_ready));
    // R2
    single_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=> (in_ready && !out_valid));
  end

  if (KIND == LINK_DUAL) begin : g_dual
    // R4
    dual_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> out_valid);
    // R4
    dual_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);
  end

  if (KIND == LINK_WIRE) begin : g_wire
    // R5
    wire_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> out_valid);
    // R6
    wire_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> (out_valid && !out_ready));
  end else begin : g_hold
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  end
endmodule

bind chan_link chan_link_chk #(.W(W), .KIND(KIND)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .proto_err(proto_err)
);

// File: tb/chan_link_agent.sv
`timescale 1ns/1ps
module chan_link_agent
  import chan_link_pkg::*;
#(
  parameter int         W           = 16,
  parameter link_kind_e KIND        = LINK_SINGLE,
  parameter int         SEED        = 1,
  parameter int         RAND_CYCLES = 3000
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_bad,
  output logic done
);
  logic         in_valid, in_ready, out_valid, out_ready, proto_err;
  logic [W-1:0] in_data, out_data;

  chan_link #(.W(W), .KIND(KIND)) u_chan_link (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .proto_err(proto_err)
  );

  logic [W-1:0] exp_q[$];
  logic         c_in_ready, c_out_valid, c_err, c_acc, c_rd;
  logic [W-1:0] c_out_data;
  logic         hold_prev;
  logic [W-1:0] hold_data;
  logic [W-1:0] seq;

  // Deliveries expected in a window of full-rate traffic from empty
  function automatic int exp_stream_reads(link_kind_e k, int cycles);
    case (k)
      LINK_SINGLE: return cycles / 2;
      LINK_DUAL:   return cycles - 1;
      default:     return cycles;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s kind=%0d %s act=%0h exp=%0h", req, KIND, what, act, exp);
    end
  endtask

  // mode: 0 idle, 1 write if ready, 2 write regardless
  task automatic step(input bit ordy, input int mode, input logic [W-1:0] d);
    logic [W-1:0] e;
    @(negedge clk);
    out_ready = ordy;
    #0.5;
    in_valid = (mode == 2) || (mode == 1 && in_ready);
    in_data  = d;
    #0.5;
    c_in_ready  = in_ready;
    c_out_valid = out_valid;
    c_out_data  = out_data;
    c_err       = proto_err;
    c_acc       = in_valid && in_ready;
    c_rd        = out_valid && out_ready;
    if (KIND != LINK_WIRE && hold_prev)
      check(c_out_valid && c_out_data == hold_data, "R8", "held data",
            32'(c_out_data), 32'(hold_data));
    hold_prev = c_out_valid && !ordy;
    hold_data = c_out_data;
    if (c_acc) exp_q.push_back(d);
    if (c_rd) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "read with nothing expected", 32'(c_out_data), 32'h0);
      end else begin
        e = exp_q.pop_front();
        check(c_out_data == e, "R1", "delivery order", 32'(c_out_data), 32'(e));
      end
    end
    @(posedge clk);
  endtask

  initial begin
    int cnt;
    n_chk = 0; n_bad = 0; done = 1'b0;
    in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    hold_prev = 1'b0; hold_data = '0; seq = 16'h0100;
    void'($urandom(SEED));
    wait (rst_n);
    step(0, 0, '0);
    check(!c_out_valid, "R9", "out_valid after reset", 32'(c_out_valid), 32'h0);
    check(c_in_ready, "R9", "in_ready after reset", 32'(c_in_ready), 32'h1);
    check(!c_err, "R9", "proto_err after reset", 32'(c_err), 32'h0);

    if (KIND == LINK_SINGLE) begin
      step(0, 1, 16'h0011);
      check(c_acc, "R2", "accept when empty", 32'(c_acc), 32'h1);
      step(0, 0, '0);
      check(!c_in_ready, "R2", "ready low when full", 32'(c_in_ready), 32'h0);
      check(c_out_valid && c_out_data == 16'h0011, "R2", "offered next cycle",
            32'(c_out_data), 32'h11);
      step(1, 0, '0);
      check(!c_in_ready, "R2", "ready low in read cycle", 32'(c_in_ready), 32'h0);
      step(0, 0, '0);
      check(c_in_ready && !c_out_valid, "R2", "ready back after read",
            32'(c_in_ready), 32'h1);
    end else if (KIND == LINK_DUAL) begin
      step(0, 1, 16'h0021);
      step(0, 1, 16'h0022);
      check(c_in_ready && c_out_valid && c_out_data == 16'h0021, "R4",
            "one held, still ready", 32'(c_out_data), 32'h21);
      step(0, 0, '0);
      check(!c_in_ready, "R4", "ready low with two held", 32'(c_in_ready), 32'h0);
      check(c_out_data == 16'h0021, "R4", "older first", 32'(c_out_data), 32'h21);
      step(1, 0, '0);
      step(1, 0, '0);
      check(c_in_ready && c_out_data == 16'h0022, "R4", "second after first",
            32'(c_out_data), 32'h22);
      step(0, 0, '0);
      check(!c_out_valid, "R4", "empty after two reads", 32'(c_out_valid), 32'h0);
    end else begin
      step(1, 1, 16'h0031);
      check(c_out_valid && c_out_data == 16'h0031 && c_rd, "R5", "same-cycle bypass",
            32'(c_out_data), 32'h31);
      step(0, 0, '0);
      check(!c_out_valid, "R5", "nothing retained", 32'(c_out_valid), 32'h0);
      step(0, 1, 16'h0032);
      step(0, 0, '0);
      check(!c_in_ready, "R6", "ready low full and blocked", 32'(c_in_ready), 32'h0);
      check(c_out_valid && c_out_data == 16'h0032, "R6", "stored offered",
            32'(c_out_data), 32'h32);
      step(1, 1, 16'h0033);
      check(c_in_ready && c_acc, "R6", "ready while full and read", 32'(c_in_ready), 32'h1);
      check(c_out_data == 16'h0032, "R6", "stored ahead of bypass", 32'(c_out_data), 32'h32);
      step(0, 0, '0);
      check(c_out_valid && c_out_data == 16'h0033, "R6", "refill stored",
            32'(c_out_data), 32'h33);
      step(1, 0, '0);
    end

    // R3 full-rate window
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      step(1, 1, seq);
      seq++;
      if (c_rd) cnt++;
    end
    check(cnt == exp_stream_reads(KIND, 20), "R3", "deliveries in 20 cycles",
          32'(cnt), 32'(exp_stream_reads(KIND, 20)));
    repeat (3) step(1, 0, '0);

    // R1 random traffic
    for (int i = 0; i < RAND_CYCLES; i++)
      step(($urandom % 4) != 0, ($urandom % 3) != 0 ? 1 : 0, W'($urandom));
    repeat (4) step(1, 0, '0);
    check(exp_q.size() == 0, "R1", "all accepted delivered", 32'(exp_q.size()), 32'h0);
    check(!c_err, "R7", "no spurious error", 32'(c_err), 32'h0);

    // R7 write while not ready
    repeat (3) begin
      step(0, 1, seq);
      seq++;
    end
    step(0, 2, 16'h0BAD);
    check(!c_in_ready, "R7", "precondition not ready", 32'(c_in_ready), 32'h0);
    step(0, 0, '0);
    check(c_err, "R7", "error raised", 32'(c_err), 32'h1);
    repeat (3) step(1, 0, '0);
    step(0, 0, '0);
    check(!c_out_valid, "R7", "ignored write not delivered", 32'(c_out_valid), 32'h0);
    check(c_err && exp_q.size() == 0, "R7", "error sticky", 32'(c_err), 32'h1);
    done = 1'b1;
  end
endmodule

// File: tb/chan_link_bench.sv
`timescale 1ns/1ps
module chan_link_bench;
  import chan_link_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int   c0, b0, c1, b1, c2, b2;
  logic d0, d1, d2;

  chan_link_agent #(.W(16), .KIND(LINK_SINGLE), .SEED(11)) u_agent_single (
    .clk(clk), .rst_n(rst_n), .n_chk(c0), .n_bad(b0), .done(d0));
  chan_link_agent #(.W(16), .KIND(LINK_DUAL), .SEED(23)) u_agent_dual (
    .clk(clk), .rst_n(rst_n), .n_chk(c1), .n_bad(b1), .done(d1));
  chan_link_agent #(.W(16), .KIND(LINK_WIRE), .SEED(37)) u_agent_wire (
    .clk(clk), .rst_n(rst_n), .n_chk(c2), .n_bad(b2), .done(d2));

  initial begin
    int cyc;
    int wd;
    wd = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!(d0 && d1 && d2) && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!(d0 && d1 && d2)) begin
      wd = 1;
      $display("FAIL watchdog act=%0d exp=done", cyc);
    end
    $display("  test done: total=%0d bad=%0d", c0 + c1 + c2 + wd, b0 + b1 + b2 + wd);
    $finish;
  end
endmodule